// File: doc/BRIEF.md
# Serial controller status register with set/clear command port

This block holds the status and mode state of a serial controller: a run/configuration enable bit, a master-select bit, a busy flag copied from the serial engine, and six sticky error flags. The six flags are transmit overflow, receive overflow, abort, transmit underflow, receive underflow and mode error. Software never writes the status word directly. Instead it issues a 16-bit command word. Every status bit has its own set bit and its own clear bit in that word, so one access can change any mix of bits and leave the others alone. A command bit at zero has no effect.

The serial engine reports error events on dedicated inputs. Five of them are gated by enable bits that the control register supplies. The mode-error event is not gated. When any error flag goes from 0 to 1, the block raises a one-cycle error interrupt pulse. The enable bit may only be cleared, which enters configuration mode, while the status busy flag is low. A clear request made while busy is high is dropped.

Top module: `sts_cmd_reg`

## Requirements
- R1: After reset the status word reads 0x0000 and `err_irq` is low.
- R2: A command with bit 1 set sets the enable bit (status bit 0), and bit 0 clears it. A command with bit 3 set sets master select (status bit 1), and bit 2 clears it. Each update is visible one clock after the command.
- R3: Error flag bits are mapped as follows. Command bits 12, 13, 14 and 15 set the transmit-overflow, receive-overflow, abort and transmit-underflow flags, and bits 8, 9, 10 and 11 clear them. Command bit 5 sets the receive-underflow flag and bit 4 clears it. Command bit 7 sets the mode-error flag and bit 6 clears it. The flags appear at status bits 8, 9, 10, 11, 12 and 14 respectively.
- R4: The command value 0x0F50 clears all six error flags in one access and leaves enable and master select unchanged.
- R5: If one command has both the set bit and the clear bit of the same flag high, the flag ends up set.
- R6: An event on `err_event[k]` sets the error flag at status bit 8+k only when `err_gate[k]` is high. When the gate is low, the event is ignored. `mode_err_event` sets the mode-error flag without any gate.
- R7: If an enabled hardware error event and a clear command for the same flag arrive in the same cycle, the flag is set afterwards.
- R8: `err_irq` is high for exactly one cycle, in the same cycle that any error flag first reads 1 after having been 0. It stays low when a flag that is already set is set again.
- R9: Status bit 13 shows `busy_in` delayed by one clock. A command that clears the enable bit has no effect while status bit 13 is high.
- R10: When `cmd_valid` is low, `cmd_word` is ignored. Status bits 2 to 7 and bit 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word is valid this cycle |
| cmd_word | input | 16 | Set/clear command bits |
| err_gate | input | 5 | Per-error enables from the control register (transmit overflow, receive overflow, abort, transmit underflow, receive underflow) |
| err_event | input | 5 | Error events from the serial engine, same order as the gates |
| mode_err_event | input | 1 | Mode-error event (not gated) |
| busy_in | input | 1 | Serial engine busy |
| status | output | 16 | Status word |
| err_irq | output | 1 | One-cycle pulse on a new error flag |

## Verification
The bench aims at the conflict cases. The first is set and clear of the same flag in one word: a design that let clear win would read the flag as 0. The second is a gated event that coincides with a clear: a design that gave the clear priority would drop the error. The third is an event whose gate is low: a design that set the flag anyway would report errors that are disabled. The bench also re-sets a flag that is already set, where a level-driven interrupt would pulse again, and it requests a clear of enable while busy is high, where a design without the guard would drop to configuration mode in the middle of a transfer. Whole-word compares catch any misplaced command or status bit, including the all-errors clear value.

// File: rtl/sts_cmd_reg.sv
module sts_cmd_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [15:0] cmd_word,
  input  logic [4:0]  err_gate,
  input  logic [4:0]  err_event,
  input  logic        mode_err_event,
  input  logic        busy_in,
  output logic [15:0] status,
  output logic        err_irq
);
  localparam int NERR = 6;

  logic            en_q, ms_q, busy_q, irq_q;
  logic [NERR-1:0] err_q, err_d, set_v, clr_v, hw_v;
  logic            en_d, ms_d;

  // flag order: tx ovf, rx ovf, abort, tx under, rx under, mode
  assign set_v = cmd_valid ? {cmd_word[7], cmd_word[5], cmd_word[15:12]} : '0;
  assign clr_v = cmd_valid ? {cmd_word[6], cmd_word[4], cmd_word[11:8]}  : '0;
  assign hw_v  = {mode_err_event, err_event & err_gate};

  for (genvar i = 0; i < NERR; i++) begin : g_flag
    assign err_d[i] = set_v[i] | hw_v[i] | (err_q[i] & ~clr_v[i]);
  end

  assign en_d = (cmd_valid & cmd_word[1]) ? 1'b1 :
                (cmd_valid & cmd_word[0] & ~busy_q) ? 1'b0 : en_q;
  assign ms_d = (cmd_valid & cmd_word[3]) ? 1'b1 :
                (cmd_valid & cmd_word[2]) ? 1'b0 : ms_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ms_q   <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      ms_q   <= ms_d;
      busy_q <= busy_in;
      err_q  <= err_d;
      irq_q  <= |(err_d & ~err_q);
    end
  end

  assign status  = {1'b0, err_q[5], busy_q, err_q[4:0], 6'b0, ms_q, en_q};
  assign err_irq = irq_q;
endmodule

module sts_cmd_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [15:0] cmd_word,
  input logic [4:0]  err_gate,
  input logic [4:0]  err_event,
  input logic        busy_in,
  input logic [15:0] status,
  input logic        err_irq
);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_word[12] && cmd_word[8]) |=> status[8]);

  p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !err_gate[1] && !status[9]) |=> !status[9]);

  p_hw_beats_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_event[2] && err_gate[2]) |=> status[10]);

  p_irq_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (err_irq == (|({status[14], status[12:8]} & ~$past({status[14], status[12:8]})))));

  p_busy_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (status[13] == $past(busy_in)));

  p_en_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_word[0] && !cmd_word[1] && status[13]) |=> $stable(status[0]));

  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7:2] == 6'b0) && !status[15]);
endmodule

bind sts_cmd_reg sts_cmd_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .err_gate(err_gate), .err_event(err_event), .busy_in(busy_in),
  .status(status), .err_irq(err_irq)
);

// File: tb/tb_sts_cmd_reg.sv
module tb_sts_cmd_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [4:0]  err_gate = '0;
  logic [4:0]  err_event = '0;
  logic        mode_err_event = 1'b0;
  logic        busy_in = 1'b0;
  logic [15:0] status;
  logic        err_irq;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  sts_cmd_reg dut (.*);

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // one-cycle stimulus, then sample at the following negedge
  task automatic step(logic v, logic [15:0] w, logic [4:0] g, logic [4:0] e, logic m);
    @(negedge clk);
    cmd_valid = v; cmd_word = w; err_gate = g; err_event = e; mode_err_event = m;
    @(negedge clk);
    cmd_valid = 0; cmd_word = '0; err_event = '0; mode_err_event = 0;
  endtask

  task automatic wr(logic [15:0] w);
    step(1'b1, w, '0, '0, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 status", status, 16'h0000);
    chk("R1 irq", {15'b0, err_irq}, 16'h0);
  endtask

  task automatic t_mode_bits;
    wr(16'h0002); chk("R2 set enable", status, 16'h0001);
    wr(16'h0008); chk("R2 set master", status, 16'h0003);
    wr(16'h0004); chk("R2 clr master", status, 16'h0001);
  endtask

  task automatic t_err_cmds;
    wr(16'h1000); chk("R3 set txovf", status, 16'h0101);
    chk("R8 irq new", {15'b0, err_irq}, 16'h1);
    wr(16'h0100); chk("R3 clr txovf", status, 16'h0001);
    wr(16'hF0A0); chk("R3 set all", status, 16'h5F01);
    chk("R8 irq all", {15'b0, err_irq}, 16'h1);
    wr(16'h0F50); chk("R4 clear all", status, 16'h0001);
    chk("R4 irq low", {15'b0, err_irq}, 16'h0);
  endtask

  task automatic t_irq;
    wr(16'h0020); chk("R8 first rise", {15'b0, err_irq}, 16'h1);
    @(negedge clk); chk("R8 one cycle", {15'b0, err_irq}, 16'h0);
    wr(16'h0020); chk("R8 already set", {15'b0, err_irq}, 16'h0);
    chk("R3 rxund bit12", status, 16'h1001);
    wr(16'h0010); chk("R3 clr rxund", status, 16'h0001);
  endtask

  task automatic t_set_wins;
    wr(16'h1100); chk("R5 set wins", status, 16'h0101);
    wr(16'h0080 | 16'h0040); chk("R5 mode set wins", status, 16'h4101);
    wr(16'h0F50); chk("R5 cleanup", status, 16'h0001);
  endtask

  task automatic t_gate;
    step(1'b0, '0, 5'b00000, 5'b00010, 1'b0);
    chk("R6 gate off", status, 16'h0001);
    chk("R6 gate off irq", {15'b0, err_irq}, 16'h0);
    step(1'b0, '0, 5'b00010, 5'b00010, 1'b0);
    chk("R6 gate on", status, 16'h0201);
    step(1'b0, '0, 5'b00000, 5'b00000, 1'b1);
    chk("R6 mode ungated", status, 16'h4201);
    step(1'b1, 16'h0F50, 5'b11111, 5'b10000, 1'b0);
    chk("R7 rxund event vs clear all", status, 16'h1001);
    wr(16'h0F50);
  endtask

  task automatic t_hw_vs_clr;
    step(1'b1, 16'h0400, 5'b00100, 5'b00100, 1'b0);
    chk("R7 hw beats clr", status, 16'h0401);
    wr(16'h0400); chk("R7 clr later", status, 16'h0001);
  endtask

  task automatic t_busy;
    @(negedge clk); busy_in = 1'b1;
    @(negedge clk); chk("R9 busy shown", status, 16'h2001);
    wr(16'h0001); chk("R9 clr en blocked", status, 16'h2001);
    @(negedge clk); busy_in = 1'b0;
    @(negedge clk); chk("R9 busy low", status, 16'h0001);
    wr(16'h0001); chk("R9 clr en idle", status, 16'h0000);
  endtask

  task automatic t_ignore;
    step(1'b0, 16'hFFFF, '0, '0, 1'b0);
    chk("R10 valid low", status, 16'h0000);
    wr(16'hFFFF); chk("R10 reserved zero", status, 16'h5F03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_bits();
    t_err_cmds();
    t_irq();
    t_set_wins();
    t_gate();
    t_hw_vs_clr();
    t_busy();
    t_ignore();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule